// File: doc/BRIEF.md
# External Memory Bank Interface

This block connects one internal requester to an external memory bus. Each request carries a 32-bit address, a read/write flag and write data. The block decodes the high part of the address into one of four bank strobes, or into an unbanked strobe for addresses above the last bank. It then holds the external address, strobes and data steady for as long as the access lasts.

The length of an access is set per region by a 3-bit wait count. A mode selects how that count works together with an external acknowledge input. A one-cycle ready pulse goes back to the requester in the final cycle of the access, and read data is returned in that same cycle.

For page-mode DRAM, the block keeps the row page of the last access made to each bank. It raises a page-hit output when a new access to that bank stays in the same page.

Top module: `ext_bank_if`

## Requirements
- R1: While reset is asserted and after it is released with no request, ext_rd_o, ext_we_o, ext_bank_sel_o, ext_unbanked_o, ext_page_hit_o, req_ready_o and ext_addr_o are all zero.
- R2: Let the region index be req_addr_i shifted right by cfg_bank_shift_i. An index of 0 to 3 drives bit <index> of ext_bank_sel_o for the whole access, and any larger index drives ext_unbanked_o instead. Exactly one strobe is high during an access.
- R3: With cfg_mode_i = 2'b00 (count only), an access lasts w+1 cycles. Here w is cfg_wait_i[3r+2:3r], where r is the bank index, or 4 for the unbanked region, and ext_ack_i is ignored.
- R4: With cfg_mode_i = 2'b01 (acknowledge only), the access ends in the first of its cycles in which ext_ack_i is high, including its first cycle.
- R5: With cfg_mode_i = 2'b10 (both), the access ends in the first cycle in which the count has expired (cycle index at least w) and ext_ack_i is high.
- R6: With cfg_mode_i = 2'b11 (either), the access ends in the first cycle in which the count has expired or ext_ack_i is high.
- R7: req_ready_o is high for exactly the final cycle of an access. For a read, req_rdata_o equals ext_data_i in that cycle, and it is zero for a write. The block is idle in the following cycle.
- R8: During an access, ext_addr_o carries the request address and ext_we_o (write) or ext_rd_o (read) stays high. ext_data_o carries all 48 bits of write data for a write and is zero for a read. All of these stay stable until the access ends.
- R9: A request is taken only when the block is idle. req_valid_i and the request fields seen during an access have no effect on that access.
- R10: ext_page_hit_o is high during an access to a bank when the previous access to the same bank had equal address bits [31:10]. It is low for the first access to a bank after reset and for unbanked accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bank_shift_i | input | 5 | Log2 of the bank size in words |
| cfg_wait_i | input | 15 | Five 3-bit wait counts, banks 0..3 then unbanked |
| cfg_mode_i | input | 2 | Wait mode: count, acknowledge, both, either |
| req_valid_i | input | 1 | Request present (taken when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 48 | Request write data |
| req_ready_o | output | 1 | Final-cycle pulse of an access |
| req_rdata_o | output | 48 | Read data, valid with req_ready_o |
| ext_addr_o | output | 32 | External address bus |
| ext_data_o | output | 48 | External write data |
| ext_data_i | input | 48 | External read data |
| ext_rd_o | output | 1 | Read strobe |
| ext_we_o | output | 1 | Write strobe |
| ext_bank_sel_o | output | 4 | Bank select strobes |
| ext_unbanked_o | output | 1 | Unbanked region strobe |
| ext_page_hit_o | output | 1 | Same-page access to the selected bank |
| ext_ack_i | input | 1 | External acknowledge |

## Verification
The bench drives wait counts of zero and seven, and acknowledge arrivals both before and after the count expires, in every mode. A design that confused the both and either modes, or counted one cycle too many or too few, would end accesses in the wrong cycle. Bank boundaries are tested at several shift values, including addresses just above the last bank; an off-by-one compare would strobe a bank where the unbanked line belongs. Page tracking is checked for per-bank independence and for the first access after reset. Request noise during accesses would expose a design that takes new work while busy.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  typedef enum logic [1:0] {
    WM_COUNT  = 2'b00,
    WM_ACK    = 2'b01,
    WM_BOTH   = 2'b10,
    WM_EITHER = 2'b11
  } wait_mode_e;

  localparam int unsigned ADDR_W = 32;
endpackage

// File: rtl/ebi_decode.sv
module ebi_decode #(
  parameter int unsigned NBANK   = 4,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned SHIFT_W = $clog2(ADDR_W),
  localparam int unsigned RIDX_W  = $clog2(NBANK + 1)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [NBANK-1:0]   sel_o,
  output logic               unb_o,
  output logic [RIDX_W-1:0]  region_o
);
  logic [ADDR_W-1:0] hi;

  assign hi    = addr_i >> shift_i;
  assign unb_o = (hi >= ADDR_W'(NBANK));

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    assign sel_o[b] = (hi == ADDR_W'(b));
  end

  assign region_o = unb_o ? RIDX_W'(NBANK) : hi[RIDX_W-1:0];
endmodule

// File: rtl/ebi_wait_ctrl.sv
module ebi_wait_ctrl
  import ebi_pkg::*;
#(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              active_i,
  input  wait_mode_e        mode_i,
  input  logic              ack_i,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              expired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (active_i && !expired)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  always_comb begin
    unique case (mode_i)
      WM_COUNT:  done_o = active_i & expired;
      WM_ACK:    done_o = active_i & ack_i;
      WM_BOTH:   done_o = active_i & expired & ack_i;
      default:   done_o = active_i & (expired | ack_i);
    endcase
  end
endmodule

// File: rtl/ebi_page_track.sv
module ebi_page_track #(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned COL_W  = 10,
  localparam int unsigned PAGE_W = ADDR_W - COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [NBANK-1:0]  sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] page;
  logic [NBANK-1:0]  hit_b;

  assign page = addr_i[ADDR_W-1:COL_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [PAGE_W-1:0] page_q;
    logic              vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q <= '0;
        vld_q  <= 1'b0;
      end else if (upd_i && sel_i[b]) begin
        page_q <= page;
        vld_q  <= 1'b1;
      end
    end

    assign hit_b[b] = vld_q && (page_q == page);
  end

  assign hit_o = |(hit_b & sel_i);
endmodule

// File: rtl/ext_bank_if.sv
module ext_bank_if
  import ebi_pkg::*;
#(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned COL_W  = 10,
  parameter bit          BUS_48 = 1'b1,
  localparam int unsigned DW      = BUS_48 ? 48 : 32,
  localparam int unsigned SHIFT_W = $clog2(ADDR_W),
  localparam int unsigned RIDX_W  = $clog2(NBANK + 1),
  localparam int unsigned NREG    = NBANK + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SHIFT_W-1:0]       cfg_bank_shift_i,
  input  logic [NREG*WAIT_W-1:0]   cfg_wait_i,
  input  logic [1:0]               cfg_mode_i,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DW-1:0]            req_wdata_i,
  output logic                     req_ready_o,
  output logic [DW-1:0]            req_rdata_o,
  output logic [ADDR_W-1:0]        ext_addr_o,
  output logic [DW-1:0]            ext_data_o,
  input  logic [DW-1:0]            ext_data_i,
  output logic                     ext_rd_o,
  output logic                     ext_we_o,
  output logic [NBANK-1:0]         ext_bank_sel_o,
  output logic                     ext_unbanked_o,
  output logic                     ext_page_hit_o,
  input  logic                     ext_ack_i
);
  logic               active_q, write_q, unb_q, hit_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DW-1:0]      wdata_q;
  logic [NBANK-1:0]   sel_q;

  logic               accept, done;
  logic [NBANK-1:0]   dec_sel;
  logic               dec_unb, page_hit;
  logic [RIDX_W-1:0]  region;
  logic [WAIT_W-1:0]  wait_val;

  assign accept = req_valid_i && !active_q;

  ebi_decode #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_decode (
    .addr_i   (req_addr_i),
    .shift_i  (cfg_bank_shift_i),
    .sel_o    (dec_sel),
    .unb_o    (dec_unb),
    .region_o (region)
  );

  assign wait_val = cfg_wait_i[region*WAIT_W +: WAIT_W];

  ebi_wait_ctrl #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (wait_val),
    .active_i   (active_q),
    .mode_i     (wait_mode_e'(cfg_mode_i)),
    .ack_i      (ext_ack_i),
    .done_o     (done)
  );

  ebi_page_track #(.NBANK(NBANK), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (accept),
    .sel_i  (dec_sel),
    .addr_i (req_addr_i),
    .hit_o  (page_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      sel_q    <= '0;
      unb_q    <= 1'b0;
      hit_q    <= 1'b0;
    end else if (accept) begin
      active_q <= 1'b1;
      write_q  <= req_write_i;
      addr_q   <= req_addr_i;
      wdata_q  <= req_wdata_i;
      sel_q    <= dec_sel;
      unb_q    <= dec_unb;
      hit_q    <= page_hit;
    end else if (done) begin
      active_q <= 1'b0;
    end
  end

  assign ext_addr_o     = active_q ? addr_q : '0;
  assign ext_data_o     = (active_q && write_q) ? wdata_q : '0;
  assign ext_rd_o       = active_q && !write_q;
  assign ext_we_o       = active_q && write_q;
  assign ext_bank_sel_o = active_q ? sel_q : '0;
  assign ext_unbanked_o = active_q && unb_q;
  assign ext_page_hit_o = active_q && hit_q;
  assign req_ready_o    = done;
  assign req_rdata_o    = (done && !write_q) ? ext_data_i : '0;
endmodule

// File: rtl/ext_bank_if_chk.sv
module ext_bank_if_chk #(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DW     = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cfg_mode_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic [DW-1:0]     ext_data_o,
  input logic              ext_rd_o,
  input logic              ext_we_o,
  input logic [NBANK-1:0]  ext_bank_sel_o,
  input logic              ext_unbanked_o,
  input logic              ext_page_hit_o,
  input logic              ext_ack_i
);
  logic busy;
  assign busy = ext_rd_o || ext_we_o;

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $countones({ext_bank_sel_o, ext_unbanked_o}) == 1);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> $countones({ext_bank_sel_o, ext_unbanked_o}) == 0);

  a_r4_ack_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && cfg_mode_i == 2'b01) |-> ext_ack_i);

  a_r5_both_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && cfg_mode_i == 2'b10) |-> ext_ack_i);

  a_r7_ready_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> busy);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !req_ready_o) |=> ($stable(ext_addr_o) && $stable(ext_data_o) && busy));

  a_r8_rd_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rd_o && ext_we_o));

  a_r10_no_unbanked_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_page_hit_o |-> (busy && !ext_unbanked_o));
endmodule

bind ext_bank_if ext_bank_if_chk #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_mode_i     (cfg_mode_i),
  .req_ready_o    (req_ready_o),
  .ext_addr_o     (ext_addr_o),
  .ext_data_o     (ext_data_o),
  .ext_rd_o       (ext_rd_o),
  .ext_we_o       (ext_we_o),
  .ext_bank_sel_o (ext_bank_sel_o),
  .ext_unbanked_o (ext_unbanked_o),
  .ext_page_hit_o (ext_page_hit_o),
  .ext_ack_i      (ext_ack_i)
);

// File: tb/sim_ext_bank_if.sv
module sim_ext_bank_if;
  localparam int NBANK = 4;
  localparam int COL_W = 10;
  localparam int DW    = 48;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [4:0]      cfg_bank_shift_i = 5'd28;
  logic [14:0]     cfg_wait_i = '0;
  logic [1:0]      cfg_mode_i = 2'b00;
  logic            req_valid_i = 1'b0;
  logic            req_write_i = 1'b0;
  logic [31:0]     req_addr_i = '0;
  logic [DW-1:0]   req_wdata_i = '0;
  logic            req_ready_o;
  logic [DW-1:0]   req_rdata_o;
  logic [31:0]     ext_addr_o;
  logic [DW-1:0]   ext_data_o;
  logic [DW-1:0]   ext_data_i = '0;
  logic            ext_rd_o, ext_we_o, ext_unbanked_o, ext_page_hit_o;
  logic [NBANK-1:0] ext_bank_sel_o;
  logic            ext_ack_i = 1'b0;

  always #10 clk_i = ~clk_i;

  ext_bank_if u0 (.*);

  int total = 0;
  int bad = 0;
  logic [21:0] last_pg [NBANK];
  bit          pg_vld  [NBANK];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_end(input int mode, input int w, input int a);
    case (mode)
      0: return w;
      1: return a;
      2: return (w > a) ? w : a;
      default: return (w < a) ? w : a;
    endcase
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic access(input bit wr, input logic [31:0] addr, input logic [DW-1:0] wd,
                        input int mode, input int ackfrom, input bit noise);
    logic [31:0]      idx;
    bit               unb;
    int               r, w, ex, k;
    logic [NBANK-1:0] esel;
    bit               ehit, done, stable_ok;
    logic [DW-1:0]    rv;
    idx  = addr >> cfg_bank_shift_i;
    unb  = (idx >= NBANK);
    r    = unb ? NBANK : int'(idx);
    w    = int'((cfg_wait_i >> (3 * r)) & 15'd7);
    esel = unb ? '0 : NBANK'(1 << r);
    ehit = 1'b0;
    if (!unb) begin
      ehit = pg_vld[r] && (last_pg[r] == addr[31:COL_W]);
      pg_vld[r]  = 1'b1;
      last_pg[r] = addr[31:COL_W];
    end
    ex = exp_end(mode, w, ackfrom);
    rv = {$urandom, $urandom};
    stable_ok = 1'b1;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_wdata_i = wd;
    cfg_mode_i = 2'(mode); ext_data_i = rv; ext_ack_i = 1'b0;
    @(posedge clk_i);
    k = 0; done = 1'b0;
    while (!done && k < 40) begin
      @(negedge clk_i);
      if (noise) begin
        req_valid_i = 1'($urandom); req_addr_i = $urandom; req_write_i = 1'($urandom);
      end else req_valid_i = 1'b0;
      ext_ack_i = (k >= ackfrom);
      #1;
      if (k == 0) begin
        chk(ext_bank_sel_o == esel, "R2", "bank select", 64'(ext_bank_sel_o), 64'(esel));
        chk(ext_unbanked_o == unb, "R2", "unbanked", 64'(ext_unbanked_o), 64'(unb));
        chk(ext_page_hit_o == ehit, "R10", "page hit", 64'(ext_page_hit_o), 64'(ehit));
        chk(ext_addr_o == addr && ext_we_o == wr && ext_rd_o == !wr &&
            ext_data_o == (wr ? wd : '0), "R8", "bus drive", 64'(ext_data_o), 64'(wr ? wd : '0));
      end else begin
        if (!(ext_addr_o == addr && ext_bank_sel_o == esel && ext_we_o == wr &&
              ext_rd_o == !wr && ext_data_o == (wr ? wd : '0))) stable_ok = 1'b0;
      end
      if (req_ready_o) begin
        done = 1'b1;
        chk(req_rdata_o == (wr ? '0 : rv), "R7", "read data", 64'(req_rdata_o), 64'(wr ? '0 : rv));
      end else k++;
    end
    chk(done && k == ex, mode_tag(mode), "end cycle", 64'(k), 64'(ex));
    chk(stable_ok, noise ? "R9" : "R8", "held during access", 64'(stable_ok), 64'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0; ext_ack_i = 1'b0;
    #1;
    chk(!req_ready_o && !ext_rd_o && !ext_we_o && ext_bank_sel_o == '0 && !ext_unbanked_o,
        "R7", "idle after access", 64'({req_ready_o, ext_rd_o, ext_we_o}), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int dummy;
    dummy = $urandom(32'd4711);
    for (int i = 0; i < NBANK; i++) begin pg_vld[i] = 1'b0; last_pg[i] = '0; end

    repeat (3) @(negedge clk_i);
    chk(!ext_rd_o && !ext_we_o && ext_bank_sel_o == '0 && !ext_unbanked_o && !ext_page_hit_o &&
        !req_ready_o && ext_addr_o == '0, "R1", "in reset", 64'(ext_addr_o), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk(!ext_rd_o && !ext_we_o && ext_bank_sel_o == '0 && !req_ready_o,
        "R1", "after reset", 64'({ext_rd_o, ext_we_o}), 64'd0);

    // directed: decode at shift 28, waits 0,1,2,7 and 5 for unbanked
    cfg_bank_shift_i = 5'd28;
    cfg_wait_i = {3'd5, 3'd7, 3'd2, 3'd1, 3'd0};
    access(1'b0, 32'h0000_0100, '0, 0, 9, 1'b0);
    access(1'b1, 32'h1000_0000, 48'hABCD_1234_5678, 0, 0, 1'b0);
    access(1'b0, 32'h2FFF_FFFF, '0, 0, 0, 1'b0);
    access(1'b0, 32'h3000_0000, '0, 0, 0, 1'b0);
    access(1'b1, 32'h4000_0000, 48'hFFFF_FFFF_FFFF, 0, 0, 1'b0);
    access(1'b0, 32'hFFFF_FFFF, '0, 0, 0, 1'b0);
    // page tracking: same page hit, other bank keeps its page, new page miss
    access(1'b0, 32'h0000_0104, '0, 0, 0, 1'b0);
    access(1'b0, 32'h1000_0004, '0, 0, 0, 1'b0);
    access(1'b0, 32'h0000_03FF, '0, 0, 0, 1'b0);
    access(1'b0, 32'h0000_0400, '0, 0, 0, 1'b0);
    access(1'b0, 32'h4000_0000, '0, 0, 0, 1'b0);
    // modes with ack before and after count expiry
    access(1'b0, 32'h3000_0010, '0, 1, 0, 1'b0);
    access(1'b0, 32'h3000_0010, '0, 1, 9, 1'b0);
    access(1'b0, 32'h3000_0010, '0, 2, 3, 1'b0);
    access(1'b0, 32'h3000_0010, '0, 2, 9, 1'b0);
    access(1'b0, 32'h3000_0010, '0, 3, 2, 1'b0);
    access(1'b0, 32'h3000_0010, '0, 3, 9, 1'b0);
    access(1'b0, 32'h0000_0010, '0, 2, 0, 1'b0);
    // shift 30: every address banked
    cfg_bank_shift_i = 5'd30;
    access(1'b0, 32'hC000_0000, '0, 0, 0, 1'b0);
    access(1'b1, 32'h8000_0000, 48'h1, 3, 9, 1'b1);

    for (int n = 0; n < 200; n++) begin
      logic [4:0]  sh;
      logic [31:0] a;
      int          m;
      sh = 5'(24 + ($urandom % 8));
      cfg_bank_shift_i = sh;
      cfg_wait_i = 15'($urandom);
      m = int'($urandom % 4);
      a = (32'($urandom % 6) << sh) | (32'($urandom) & ((32'd1 << sh) - 1));
      if ($urandom % 3 == 0) a = {a[31:COL_W], 10'($urandom)} ;
      access(1'($urandom), a, {$urandom, $urandom}, m, int'($urandom % 10), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule